// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block joins an A bus and a B bus, each 18 bits wide by default. Every direction has its own capture register, capture clock, source select and drive enable. The B outputs carry either the live A-bus value or the A value captured last. The A outputs carry either the live B-bus value or the B value captured last. Each bus pin is modelled as three vectors: an input, an output and a per-bit drive enable. There are no tri-state nets. A drive enable of 0 stands for high impedance.

The bus is divided into halves of `HALF_W` bits. Each half has a full control set of its own, so the default build acts as two independent 9-bit transceivers. With `JOINED` set to 1, the control set of half 0 runs every half and the block acts as one 18-bit transceiver. In that case the control inputs of the other halves are ignored.

The data is plain parallel bus data with no handshake. It has no valid/ready pair and no back-pressure. An output follows its selected source combinationally, and a capture register changes only on a rising edge of its own clock.

Top module: `bus_xcvr18`

## Requirements
- R1: On a rising edge of `ab_clk[h]`, the A-to-B register of half h loads that half's `a_in` bits.
- R2: While `ab_sel[h]` is 0, the `b_out` bits of half h equal the live `a_in` bits of that half.
- R3: While `ab_sel[h]` is 1, the `b_out` bits of half h equal the value last captured from `a_in` for that half.
- R4: Every `b_oe` bit of half h equals `ab_oe[h]`. The enable is active high, and 0 means the B pins float.
- R5: On a rising edge of `ba_clk[h]`, the B-to-A register of half h loads that half's `b_in` bits.
- R6: `ba_sel[h]` selects the `a_out` source for half h: 0 gives live `b_in`, 1 gives the stored B value.
- R7: Every `a_oe` bit of half h equals the inverse of `ba_oe_n[h]`. The enable is active low, and a 1 means the A pins float.
- R8: A register keeps its contents while its clock has no rising edge, whatever its data input does.
- R9: With `JOINED`=0, the controls of a half (index 0 owns bits 8:0, index 1 owns bits 17:9) affect only that half's bits.
- R10: A capture works while the matching outputs are disabled, and the value captured then appears once the outputs are enabled in registered mode.
- R11: Both directions can capture in the same cycle without disturbing each other.
- R12: With `JOINED`=1, the control inputs at index 0 drive every half, and the control inputs at other indices have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ab_clk | input | 2 | A-to-B capture clock per half |
| ba_clk | input | 2 | B-to-A capture clock per half |
| ab_sel | input | 2 | A-to-B source select per half (0 live, 1 stored) |
| ba_sel | input | 2 | B-to-A source select per half (0 live, 1 stored) |
| ab_oe | input | 2 | B-side drive enable per half, active high |
| ba_oe_n | input | 2 | A-side drive enable per half, active low |
| a_in | input | 18 | Value sensed on the A pins |
| a_out | output | 18 | Value presented to the A pins |
| a_oe | output | 18 | Per-bit drive enable for the A pins |
| b_in | input | 18 | Value sensed on the B pins |
| b_out | output | 18 | Value presented to the B pins |
| b_oe | output | 18 | Per-bit drive enable for the B pins |

## Verification
The block has no reset, so the assertions are sampled on the rising edges of the capture clocks. They assume that bus data, selects and enables are settled before each such edge, and that no register is read in registered mode before it has captured once. The bench changes data and controls at a falling edge of its reference clock and raises a capture clock 1 ns later. It selects stored data only after a capture has happened. A second instance with `JOINED`=1 receives the same stimulus, and its expected values are built from the index-0 controls only.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Non-clock controls that steer one half of the transceiver
  typedef struct packed {
    logic ab_sel;
    logic ba_sel;
    logic ab_oe;
    logic ba_oe_n;
  } xcvr_ctl_t;
endpackage

// File: rtl/xcvr_dir.sv
module xcvr_dir #(
  parameter int W = 9
) (
  input  logic         cap_clk,
  input  logic         use_held,
  input  logic         drive_en,
  input  logic [W-1:0] src,
  output logic [W-1:0] dst,
  output logic [W-1:0] dst_en
);
  logic [W-1:0] held;

  // No reset: the register keeps its value until the next rising edge
  always_ff @(posedge cap_clk) begin
    held <= src;
  end

  assign dst    = use_held ? held : src;
  assign dst_en = {W{drive_en}};
endmodule

// File: rtl/xcvr_half.sv
module xcvr_half
  import xcvr_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  xcvr_ctl_t    ctl,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_en,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_en
);
  // A toward B: the drive enable is active high
  xcvr_dir #(.W(W)) u_ab (
    .cap_clk (clk_ab),
    .use_held(ctl.ab_sel),
    .drive_en(ctl.ab_oe),
    .src     (a_i),
    .dst     (b_o),
    .dst_en  (b_en)
  );

  // B toward A: the drive enable arrives active low
  xcvr_dir #(.W(W)) u_ba (
    .cap_clk (clk_ba),
    .use_held(ctl.ba_sel),
    .drive_en(~ctl.ba_oe_n),
    .src     (b_i),
    .dst     (a_o),
    .dst_en  (a_en)
  );
endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18
  import xcvr_pkg::*;
#(
  parameter int HALF_W     = 9,
  parameter int NUM_HALVES = 2,
  parameter bit JOINED     = 1'b0
) (
  input  logic [NUM_HALVES-1:0]        ab_clk,
  input  logic [NUM_HALVES-1:0]        ba_clk,
  input  logic [NUM_HALVES-1:0]        ab_sel,
  input  logic [NUM_HALVES-1:0]        ba_sel,
  input  logic [NUM_HALVES-1:0]        ab_oe,
  input  logic [NUM_HALVES-1:0]        ba_oe_n,
  input  logic [NUM_HALVES*HALF_W-1:0] a_in,
  output logic [NUM_HALVES*HALF_W-1:0] a_out,
  output logic [NUM_HALVES*HALF_W-1:0] a_oe,
  input  logic [NUM_HALVES*HALF_W-1:0] b_in,
  output logic [NUM_HALVES*HALF_W-1:0] b_out,
  output logic [NUM_HALVES*HALF_W-1:0] b_oe
);
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    // In joined operation every half listens to control set 0
    localparam int C  = JOINED ? 0 : h;
    localparam int LO = h * HALF_W;

    xcvr_ctl_t ctl;
    assign ctl = '{ab_sel: ab_sel[C], ba_sel: ba_sel[C],
                   ab_oe: ab_oe[C], ba_oe_n: ba_oe_n[C]};

    xcvr_half #(.W(HALF_W)) u_half (
      .clk_ab(ab_clk[C]),
      .clk_ba(ba_clk[C]),
      .ctl   (ctl),
      .a_i   (a_in[LO +: HALF_W]),
      .a_o   (a_out[LO +: HALF_W]),
      .a_en  (a_oe[LO +: HALF_W]),
      .b_i   (b_in[LO +: HALF_W]),
      .b_o   (b_out[LO +: HALF_W]),
      .b_en  (b_oe[LO +: HALF_W])
    );
  end
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int HALF_W     = 9,
  parameter int NUM_HALVES = 2,
  parameter bit JOINED     = 1'b0
) (
  input logic [NUM_HALVES-1:0]        ab_clk,
  input logic [NUM_HALVES-1:0]        ba_clk,
  input logic [NUM_HALVES-1:0]        ab_sel,
  input logic [NUM_HALVES-1:0]        ba_sel,
  input logic [NUM_HALVES-1:0]        ab_oe,
  input logic [NUM_HALVES-1:0]        ba_oe_n,
  input logic [NUM_HALVES*HALF_W-1:0] a_in,
  input logic [NUM_HALVES*HALF_W-1:0] a_out,
  input logic [NUM_HALVES*HALF_W-1:0] a_oe,
  input logic [NUM_HALVES*HALF_W-1:0] b_in,
  input logic [NUM_HALVES*HALF_W-1:0] b_out,
  input logic [NUM_HALVES*HALF_W-1:0] b_oe
);
  // The block has no reset, so no property needs a disable condition.
  // Each property is sampled on the capture clock that owns the half.
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_chk
    localparam int C  = JOINED ? 0 : h;
    localparam int LO = h * HALF_W;

    // R2: live A data reaches B while the A-to-B select is low
    a_r2_live_to_b: assert property (@(posedge ab_clk[C])
      !ab_sel[C] |-> b_out[LO +: HALF_W] == a_in[LO +: HALF_W]);

    // R4: B-side enable follows the active-high control
    a_r4_b_enable: assert property (@(posedge ab_clk[C])
      b_oe[LO +: HALF_W] == {HALF_W{ab_oe[C]}});

    // R6: live B data reaches A while the B-to-A select is low
    a_r6_live_to_a: assert property (@(posedge ba_clk[C])
      !ba_sel[C] |-> a_out[LO +: HALF_W] == b_in[LO +: HALF_W]);

    // R7: A-side enable is the inverse of the active-low control
    a_r7_a_enable: assert property (@(posedge ba_clk[C])
      a_oe[LO +: HALF_W] == {HALF_W{~ba_oe_n[C]}});

    if (JOINED && h > 0) begin : g_join
      // R12: joined halves always present identical enables
      a_r12_joined_oe: assert property (@(posedge ab_clk[0])
        b_oe[LO +: HALF_W] == b_oe[HALF_W-1:0]);
    end
  end
endmodule

bind bus_xcvr18 xcvr_chk #(
  .HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES), .JOINED(JOINED)
) u_chk (
  .ab_clk(ab_clk), .ba_clk(ba_clk), .ab_sel(ab_sel), .ba_sel(ba_sel),
  .ab_oe(ab_oe), .ba_oe_n(ba_oe_n), .a_in(a_in), .a_out(a_out),
  .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/sim_bus_xcvr18.sv
`timescale 1ns/1ps
module sim_bus_xcvr18;
  localparam int HW = 9;
  localparam int NH = 2;
  localparam int BW = HW * NH;

  typedef struct packed {
    logic [BW-1:0] ao, aen, bo, ben;
  } obs_t;

  typedef struct {
    string tag;
    obs_t  e0;
    obs_t  e1;
  } item_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [NH-1:0] ab_clk = '0, ba_clk = '0, ab_sel = '0, ba_sel = '0;
  logic [NH-1:0] ab_oe = '0, ba_oe_n = '1;
  logic [BW-1:0] a_in = '0, b_in = '0;
  logic [BW-1:0] u0_ao, u0_aen, u0_bo, u0_ben;
  logic [BW-1:0] u1_ao, u1_aen, u1_bo, u1_ben;

  bus_xcvr18 #(.HALF_W(HW), .NUM_HALVES(NH), .JOINED(1'b0)) u0 (
    .ab_clk(ab_clk), .ba_clk(ba_clk), .ab_sel(ab_sel), .ba_sel(ba_sel),
    .ab_oe(ab_oe), .ba_oe_n(ba_oe_n), .a_in(a_in), .a_out(u0_ao),
    .a_oe(u0_aen), .b_in(b_in), .b_out(u0_bo), .b_oe(u0_ben));

  // Second instance in joined mode, fed the same stimulus (R12)
  bus_xcvr18 #(.HALF_W(HW), .NUM_HALVES(NH), .JOINED(1'b1)) u1 (
    .ab_clk(ab_clk), .ba_clk(ba_clk), .ab_sel(ab_sel), .ba_sel(ba_sel),
    .ab_oe(ab_oe), .ba_oe_n(ba_oe_n), .a_in(a_in), .a_out(u1_ao),
    .a_oe(u1_aen), .b_in(b_in), .b_out(u1_bo), .b_oe(u1_ben));

  int n_run = 0, n_fail = 0;
  item_t sb[$];
  logic [HW-1:0] m_ab [2][NH];
  logic [HW-1:0] m_ba [2][NH];

  task automatic cmp(string tag, string what, logic [BW-1:0] got, logic [BW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Monitor: pops one expected item per reference edge and compares
  initial begin
    forever begin
      @(posedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        cmp(it.tag, "u0 a_out", u0_ao,  it.e0.ao);
        cmp(it.tag, "u0 a_oe",  u0_aen, it.e0.aen);
        cmp(it.tag, "u0 b_out", u0_bo,  it.e0.bo);
        cmp(it.tag, "u0 b_oe",  u0_ben, it.e0.ben);
        cmp(it.tag, "u1 a_out", u1_ao,  it.e1.ao);
        cmp(it.tag, "u1 a_oe",  u1_aen, it.e1.aen);
        cmp(it.tag, "u1 b_out", u1_bo,  it.e1.bo);
        cmp(it.tag, "u1 b_oe",  u1_ben, it.e1.ben);
      end
    end
  end

  // Driver: applies a vector, pulses the chosen capture clocks,
  // updates the requirement model and queues the expected outputs
  task automatic step(string tag, logic [BW-1:0] av, logic [BW-1:0] bv,
                      logic [1:0] asel, logic [1:0] bsel, logic [1:0] aoe,
                      logic [1:0] boen, logic [1:0] pab, logic [1:0] pba);
    item_t it;
    obs_t  e [2];
    @(negedge clk);
    ab_clk = '0; ba_clk = '0;
    a_in = av; b_in = bv; ab_sel = asel; ba_sel = bsel;
    ab_oe = aoe; ba_oe_n = boen;
    #1;
    ab_clk = pab; ba_clk = pba;
    for (int k = 0; k < 2; k++) begin
      for (int h = 0; h < NH; h++) begin
        int c;
        c = (k == 1) ? 0 : h;
        if (pab[c]) m_ab[k][h] = av[h*HW +: HW];
        if (pba[c]) m_ba[k][h] = bv[h*HW +: HW];
        e[k].bo[h*HW +: HW]  = asel[c] ? m_ab[k][h] : av[h*HW +: HW];
        e[k].ben[h*HW +: HW] = {HW{aoe[c]}};
        e[k].ao[h*HW +: HW]  = bsel[c] ? m_ba[k][h] : bv[h*HW +: HW];
        e[k].aen[h*HW +: HW] = {HW{~boen[c]}};
      end
    end
    it.tag = tag; it.e0 = e[0]; it.e1 = e[1];
    sb.push_back(it);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // Quiet start, both sides floating (R4, R7)
    step("R4 R7 idle", 18'h0, 18'h0, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00);
    // Live transfer both ways (R2, R6)
    step("R2 R4 live A", 18'h2A5C3, 18'h11111, 2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00);
    step("R6 R7 live B", 18'h00FF0, 18'h3C0F1, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00);
    // Store with outputs disabled (R1, R5, R10)
    step("R1 R10 store hidden", 18'h15A5A, 18'h0A0A5, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11);
    // Reveal stored values, bus changed without edges (R3, R8, R10)
    step("R3 R8 R10 reveal", 18'h3FFFF, 18'h00000, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00);
    // Half 0 captures alone (R9; joined copy captures all, R12)
    step("R9 R12 half0 clk", 18'h2D2D2, 18'h1E1E1, 2'b11, 2'b11, 2'b11, 2'b00, 2'b01, 2'b01);
    // Half 1 captures alone
    step("R9 R12 half1 clk", 18'h0C3C3, 18'h33CC3, 2'b11, 2'b11, 2'b11, 2'b00, 2'b10, 2'b10);
    // Both directions at once (R5, R11)
    step("R5 R11 dual store", 18'h12345, 18'h3BEEF, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 2'b11);
    // Mixed selects and enables per half (R9, R12)
    step("R9 R12 mixed sel", 18'h0AAAA, 18'h15555, 2'b01, 2'b10, 2'b10, 2'b01, 2'b00, 2'b00);
    step("R9 R12 mixed oe", 18'h3F00F, 18'h00FF0, 2'b10, 2'b01, 2'b01, 2'b10, 2'b00, 2'b00);
    // Hold with stored select while the bus keeps moving (R8)
    step("R8 hold", 18'h01234, 18'h3ABCD, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00);
    // Varied patterns with mixed controls (R1, R3, R5, R6)
    for (int i = 0; i < 24; i++) begin
      logic [BW-1:0] av, bv;
      av = BW'($urandom);
      bv = BW'($urandom);
      step("R1 R3 R5 R6 sweep", av, bv, 2'(i), 2'(i >> 1), 2'(i + 1), 2'(i >> 2),
           2'(i * 3), 2'(i * 5 + 1));
    end
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule